// File: doc/BRIEF.md
# Serial Real-Time Control Receiver

This block watches a single serial control pin and serves two purposes, chosen by a two-bit mode input. In real-time control mode it deserializes fixed-length frames sent at two clock cycles per bit, extracts a 22-bit chroma subcarrier increment from the low end of each frame, and hands that word to the phase accumulator at the next line boundary. In subcarrier-reset mode the same pin is treated as a trigger: a rising edge arms a phase reset that fires at the next field boundary. In the remaining mode codes the pin has no effect.

The increment output is a plain control word with a one-cycle update strobe. There is no ready signal and no back-pressure: the downstream accumulator is expected to take the word on every cycle, and the strobe only marks the cycle in which a newly received value took effect. Outside real-time control mode the output carries the programmable frequency word unchanged, so the accumulator always has one source to read.

Top module: `subcar_ctl_rx`

## Requirements
- R1: After reset `sc_upd` and `phase_rst` are 0, and in real-time control mode (`mode_sel` = 2'b10) `sc_word` is 0 until the first update.
- R2: With `mode_sel` = 2'b10, a frame starts when the pin is sampled high after at least IDLE_MIN (default 8) consecutive low samples; that first high bit period is the start bit, then frame bits 0 to 66 follow LSB first, each lasting 2 clocks and sampled on its second clock; the received word is frame bits 0 to 21, bit 0 in `sc_word[0]`.
- R3: Frame bits 22 to 66 are received but have no effect on the word.
- R4: A completed word is held pending and takes effect on the next `line_start`: `sc_word` changes and `sc_upd` is 1 for exactly the one cycle after the cycle in which `line_start` was sampled high.
- R5: A `line_start` with no pending word leaves `sc_word` unchanged and `sc_upd` at 0; each pending word is applied only once.
- R6: A rising edge preceded by fewer than IDLE_MIN low samples does not start a frame.
- R7: In real-time control mode `cfg_freq` has no effect on `sc_word`; in every other mode `sc_word` equals `cfg_freq`.
- R8: With `mode_sel` = 2'b01, a rising edge on the pin arms a reset; `phase_rst` stays 0 until `field_start` is sampled high, and is then 1 for the single following cycle.
- R9: `phase_rst` fires once per armed edge; a `field_start` with nothing armed, or any pin activity with `mode_sel` other than 2'b01, gives no pulse.
- R10: With `mode_sel` other than 2'b10 no frame is received, and no word becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial control pin, synchronous to clk |
| mode_sel | input | 2 | 00/11 off, 01 subcarrier reset, 10 real-time control |
| line_start | input | 1 | One-cycle strobe at each line start |
| field_start | input | 1 | One-cycle strobe at each field start |
| cfg_freq | input | 22 | Programmable subcarrier increment |
| sc_word | output | 22 | Subcarrier increment for the accumulator |
| sc_upd | output | 1 | Pulses when a received word takes effect |
| phase_rst | output | 1 | One-cycle subcarrier phase reset |

## Verification
The bench sends a walking-one word through every one of the 22 word positions with varied tail contents, so a receiver that is off by one slot, samples on the wrong clock of a bit, or reverses bit order returns a shifted or mirrored word, and one that lets tail bits leak in returns ones in the upper bits. It fires `line_start` with nothing pending and then again after an applied word, which catches a design that reapplies stale data or updates at the frame end instead of the line boundary. A short glitch after a frame and a frame sent in the wrong mode must leave the word alone; a design with no idle qualification or no mode gating would pick up a false frame. In reset mode the pulse must wait for `field_start`, so an immediate reset or one that repeats on a second field shows up directly.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    PIN_OFF   = 2'b00,
    PIN_PHRST = 2'b01,
    PIN_RTC   = 2'b10,
    PIN_OFF_B = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/scr_frame_rx.sv
module scr_frame_rx #(
  parameter int FRAME_BITS   = 67,
  parameter int WORD_BITS    = 22,
  parameter int CLKS_PER_BIT = 2,
  parameter int IDLE_MIN     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 ser_in,
  output logic                 done,
  output logic [WORD_BITS-1:0] word
);
  localparam int SLOT_W = $clog2(FRAME_BITS + 1);
  localparam int PH_W   = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDLE_W = $clog2(IDLE_MIN + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(FRAME_BITS);
  localparam logic [SLOT_W-1:0] WORD_SLOT  = SLOT_W'(WORD_BITS);
  localparam logic [PH_W-1:0]   PH_LAST    = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [IDLE_W-1:0] IDLE_FULL  = IDLE_W'(IDLE_MIN);

  logic                 busy;
  logic [SLOT_W-1:0]    slot;
  logic [PH_W-1:0]      ph;
  logic [IDLE_W-1:0]    idle_cnt;
  logic [WORD_BITS-1:0] shreg;

  // slot 0 is the start bit; slot k+1 carries frame bit k
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      slot     <= '0;
      ph       <= '0;
      idle_cnt <= '0;
      shreg    <= '0;
      word     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy     <= 1'b0;
        idle_cnt <= '0;
      end else if (!busy) begin
        if (ser_in) begin
          if (idle_cnt == IDLE_FULL) begin
            busy <= 1'b1;
            ph   <= PH_W'(1);
            slot <= '0;
          end
          idle_cnt <= '0;
        end else if (idle_cnt != IDLE_FULL) begin
          idle_cnt <= idle_cnt + 1'b1;
        end
      end else begin
        if (ph == PH_LAST) begin
          ph   <= '0;
          slot <= slot + 1'b1;
          if (slot >= SLOT_W'(1) && slot <= WORD_SLOT)
            shreg <= {ser_in, shreg[WORD_BITS-1:1]};
          if (slot == LAST_SLOT) begin
            busy <= 1'b0;
            done <= 1'b1;
            word <= shreg;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  AST_IDLE_OUTSIDE_RTC: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !done)); // R10

  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy && ser_in && idle_cnt != IDLE_FULL) |=> !busy); // R6

  AST_DONE_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
endmodule

// File: rtl/scr_word_apply.sv
module scr_word_apply #(
  parameter int WORD_BITS = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rtc_en,
  input  logic                 frame_done,
  input  logic [WORD_BITS-1:0] frame_word,
  input  logic                 line_start,
  input  logic [WORD_BITS-1:0] cfg_freq,
  output logic [WORD_BITS-1:0] sc_word,
  output logic                 sc_upd
);
  logic [WORD_BITS-1:0] pend;
  logic                 pend_v;
  logic [WORD_BITS-1:0] applied;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      pend_v  <= 1'b0;
      applied <= '0;
      sc_upd  <= 1'b0;
    end else if (!rtc_en) begin
      pend_v <= 1'b0;
      sc_upd <= 1'b0;
    end else begin
      sc_upd <= 1'b0;
      if (line_start && pend_v) begin
        applied <= pend;
        sc_upd  <= 1'b1;
        pend_v  <= 1'b0;
      end
      if (frame_done) begin
        pend   <= frame_word;
        pend_v <= 1'b1;
      end
    end
  end

  assign sc_word = rtc_en ? applied : cfg_freq;

  AST_UPD_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_upd |-> $past(line_start)); // R4

  AST_HOLD_WITHOUT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_en && !sc_upd) |-> $stable(applied)); // R5
endmodule

// File: rtl/scr_phase_reset.sv
module scr_phase_reset (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ser_in,
  input  logic field_start,
  output logic phase_rst
);
  logic pin_q;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q     <= 1'b1;
      armed     <= 1'b0;
      phase_rst <= 1'b0;
    end else begin
      pin_q <= ser_in;
      if (!enable) begin
        armed     <= 1'b0;
        phase_rst <= 1'b0;
      end else begin
        phase_rst <= 1'b0;
        if (field_start && armed) begin
          phase_rst <= 1'b1;
          armed     <= 1'b0;
        end
        if (ser_in && !pin_q)
          armed <= 1'b1;
      end
    end
  end

  AST_RST_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |-> $past(field_start)); // R8

  AST_RST_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !phase_rst); // R9
endmodule

// File: rtl/subcar_ctl_rx.sv
module subcar_ctl_rx #(
  parameter int FRAME_BITS   = 67,
  parameter int WORD_BITS    = 22,
  parameter int CLKS_PER_BIT = 2,
  parameter int IDLE_MIN     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic [1:0]           mode_sel,
  input  logic                 line_start,
  input  logic                 field_start,
  input  logic [WORD_BITS-1:0] cfg_freq,
  output logic [WORD_BITS-1:0] sc_word,
  output logic                 sc_upd,
  output logic                 phase_rst
);
  import scr_pkg::*;

  pin_mode_e            mode;
  logic                 rtc_en;
  logic                 rst_en;
  logic                 f_done;
  logic [WORD_BITS-1:0] f_word;

  assign mode   = pin_mode_e'(mode_sel);
  assign rtc_en = (mode == PIN_RTC);
  assign rst_en = (mode == PIN_PHRST);

  scr_frame_rx #(
    .FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS),
    .CLKS_PER_BIT(CLKS_PER_BIT), .IDLE_MIN(IDLE_MIN)
  ) frame_i (
    .clk(clk), .rst_n(rst_n), .enable(rtc_en), .ser_in(ser_in),
    .done(f_done), .word(f_word)
  );

  scr_word_apply #(.WORD_BITS(WORD_BITS)) apply_i (
    .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .frame_done(f_done),
    .frame_word(f_word), .line_start(line_start), .cfg_freq(cfg_freq),
    .sc_word(sc_word), .sc_upd(sc_upd)
  );

  scr_phase_reset phrst_i (
    .clk(clk), .rst_n(rst_n), .enable(rst_en), .ser_in(ser_in),
    .field_start(field_start), .phase_rst(phase_rst)
  );

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_upd && phase_rst)); // R9
endmodule

// File: tb/subcar_ctl_rx_tb_top.sv
module subcar_ctl_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_in = 1'b0;
  logic [1:0]  mode_sel = 2'b10;
  logic        line_start = 1'b0;
  logic        field_start = 1'b0;
  logic [21:0] cfg_freq = 22'h0;
  logic [21:0] sc_word;
  logic        sc_upd;
  logic        phase_rst;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  subcar_ctl_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .mode_sel(mode_sel),
    .line_start(line_start), .field_start(field_start), .cfg_freq(cfg_freq),
    .sc_word(sc_word), .sc_upd(sc_upd), .phase_rst(phase_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ser_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_in = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [21:0] w, input logic [44:0] t);
    idle(10);
    send_bit(1'b1);
    for (int k = 0; k < 22; k++) send_bit(w[k]);
    for (int k = 0; k < 45; k++) send_bit(t[k]);
    idle(3);
  endtask

  task automatic line_pulse();
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic field_pulse();
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  logic [21:0] last_word;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word", 32'(sc_word), 32'h0);
    chk("R1 upd", 32'(sc_upd), 32'h0);
    chk("R1 phase_rst", 32'(phase_rst), 32'h0);

    // R2/R3/R4: walking one through every word position, varied tails
    for (int i = 0; i < 22; i++) begin
      logic [21:0] w;
      logic [44:0] t;
      w = 22'h1 << i;
      t = (i % 3 == 0) ? {45{1'b1}} : ((i % 3 == 1) ? 45'h0 : {23{2'b10}}[44:0]);
      send_frame(w, t);
      chk("R4 no change before line", 32'(sc_word), (i == 0) ? 32'h0 : 32'(22'h1 << (i - 1)));
      line_pulse();
      chk("R4 upd strobe", 32'(sc_upd), 32'h1);
      chk("R2 R3 walking word", 32'(sc_word), 32'(w));
      @(negedge clk);
      chk("R4 upd one cycle", 32'(sc_upd), 32'h0);
    end

    // R2/R3: arithmetic patterns with noisy tails
    for (int i = 1; i <= 6; i++) begin
      logic [21:0] w;
      logic [44:0] t;
      w = 22'((32'(i) * 32'h9E3779B1) >> 7);
      t = 45'({i[12:0], 32'hA5C3_0F69} ^ 45'(i * 7919));
      send_frame(w, t);
      line_pulse();
      chk("R2 pattern word", 32'(sc_word), 32'(w));
      last_word = w;
    end

    // R5: second line_start without a new frame
    @(negedge clk);
    line_pulse();
    chk("R5 no upd", 32'(sc_upd), 32'h0);
    chk("R5 word held", 32'(sc_word), 32'(last_word));

    // R7: cfg_freq ignored in real-time mode
    cfg_freq = 22'h2A_5A5A;
    @(negedge clk);
    chk("R7 cfg ignored", 32'(sc_word), 32'(last_word));

    // R6: glitch with too short idle after a frame
    send_frame(22'h15_5AA5, 45'h0);
    for (int k = 0; k < 40; k++) send_bit(k[0]);
    idle(20);
    line_pulse();
    chk("R6 only real frame", 32'(sc_word), 32'h15_5AA5);
    line_pulse();
    chk("R6 no false frame", 32'(sc_upd), 32'h0);
    last_word = 22'h15_5AA5;

    // R10: frame sent in off mode is not received
    mode_sel = 2'b00;
    @(negedge clk);
    chk("R7 off mode passes cfg", 32'(sc_word), 32'h2A_5A5A);
    send_frame(22'h0F_0F0F, 45'h0);
    mode_sel = 2'b10;
    @(negedge clk);
    line_pulse();
    chk("R10 no pending from off mode", 32'(sc_upd), 32'h0);
    chk("R10 word kept", 32'(sc_word), 32'(last_word));

    // R8/R9: subcarrier reset mode
    mode_sel = 2'b01;
    idle(4);
    chk("R7 reset mode passes cfg", 32'(sc_word), 32'h2A_5A5A);
    ser_in = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 not immediate", 32'(phase_rst), 32'h0);
    field_pulse();
    chk("R8 pulse after field", 32'(phase_rst), 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(phase_rst), 32'h0);
    field_pulse();
    chk("R9 no pulse unarmed", 32'(phase_rst), 32'h0);
    ser_in = 1'b0;
    @(negedge clk);
    field_pulse();
    chk("R9 falling edge no pulse", 32'(phase_rst), 32'h0);

    // R9: edges in real-time mode give no pulse
    mode_sel = 2'b10;
    ser_in = 1'b1;
    @(negedge clk);
    ser_in = 1'b0;
    @(negedge clk);
    field_pulse();
    chk("R9 no pulse in rtc mode", 32'(phase_rst), 32'h0);
    mode_sel = 2'b01;
    @(negedge clk);
    field_pulse();
    chk("R9 edge from other mode not armed", 32'(phase_rst), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule